// File: doc/BRIEF.md
# Fuzzy Rule Theta Evaluator

This block turns a stream of rule words into rule activation weights for a fuzzy controller. A bank of sixteen 4-bit antecedent activation levels (alphas) is presented on a flat input bus. Each rule word picks up to four of those alphas. It may complement any of them, and it joins them left to right with AND (minimum) or OR (maximum). The block accepts one rule word per clock while it is running.

The result of each rule is folded into a per-consequent register by maximum, because rules that drive the same consequent combine only through OR. In the cycle after a word is consumed, the block presents the merged theta of the addressed consequent, that consequent's index and a valid flag. A process starts with a start pulse, which clears every consequent register. It ends when the block consumes a word whose last flag is set. One cycle after that word, a done pulse appears alongside the word's result.

The controller has three states. `ST_IDLE` waits for a start pulse and moves to `ST_CLEAR`. `ST_CLEAR` spends one cycle clearing the consequent registers and always moves to `ST_RUN`. `ST_RUN` accepts rule words and returns to `ST_IDLE` when it accepts a word marked last.

Top module: `theta_eval`

## Requirements
- R1: While reset is asserted and after its release, rule_rdy_o, theta_vld_o and done_o are low until a start pulse is given.
- R2: A start pulse seen in ST_IDLE is followed by one cycle in ST_CLEAR (rule_rdy_o low) and then ST_RUN, in which rule_rdy_o is high. During ST_CLEAR every consequent register is set to 0.
- R3: Rule word bits [4k+3:4k] for k = 0..3 choose operand k from the alpha bank, where alpha j sits at alpha_i[4j+3:4j]. Bit 16+k set replaces operand k by 15 minus its alpha.
- R4: Bits [31:30] hold the operand count minus one. The result starts from operand 0, and each further operand k is folded in by maximum when bit 19+k is 1 and by minimum when it is 0.
- R5: A word is consumed only on a clock edge where rule_vld_i and rule_rdy_o are both high, so at most one word is consumed per clock. rule_rdy_o is high only in ST_RUN, and a word offered outside ST_RUN produces no output.
- R6: One cycle after a consumed word, theta_vld_o is high, cons_o equals bits [29:23] of the word, and theta_o equals the maximum of that consequent's register and the rule result. The register takes this new value. Outputs hold their last values between results.
- R7: One cycle after a word with bit 32 set is consumed, done_o pulses together with that word's result and the block is back in ST_IDLE with rule_rdy_o low.
- R8: A start pulse outside ST_IDLE has no effect, and consequent registers keep their values.
- R9: Thetas do not carry from one process into the next: after a new start, a consequent's first result equals its rule result alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a process when the block is idle |
| alpha_i | input | 64 | Sixteen 4-bit alpha values, alpha j at bits 4j+3..4j |
| rule_vld_i | input | 1 | A rule word is offered |
| rule_i | input | 33 | Rule word (selects, negates, connectives, consequent, count, last) |
| rule_rdy_o | output | 1 | The block accepts a rule word this cycle |
| theta_vld_o | output | 1 | A merged theta is presented |
| theta_o | output | 4 | Merged theta of the addressed consequent |
| cons_o | output | 7 | Consequent index of the presented theta |
| done_o | output | 1 | One-cycle pulse after the last rule word is consumed |

## Verification
A wrong consequent register shows up at the ports the next time a rule addresses that consequent: theta_o then exceeds the maximum of that process's rule results. The bench sends many rules to the same few consequents back to back, so such an error appears within a handful of cycles. A wrong controller state shows up at once as a rule_rdy_o, theta_vld_o or done_o value that disagrees with the start pulses and last flags the bench has issued. A wrong operand, negation or connective shows up in theta_o one cycle after the word is consumed. The sweeps cover every alpha level, both operand polarities, every connective pattern and every operand count.

// File: rtl/theta_pkg.sv
`timescale 1ns/1ps
package theta_pkg;
    localparam int ALPHA_W = 4;
    localparam int N_ALPHA = 16;
    localparam int N_OPS   = 4;
    localparam int CONS_W  = 7;
    localparam int SEL_W   = $clog2(N_ALPHA);
    localparam int CNT_W   = $clog2(N_OPS);
    localparam int N_CONS  = 1 << CONS_W;
    localparam int BANK_W  = N_ALPHA * ALPHA_W;

    typedef struct packed {
        logic                             last;
        logic [CNT_W-1:0]                 cnt_m1;
        logic [CONS_W-1:0]                cons;
        logic [N_OPS-2:0]                 conn;
        logic [N_OPS-1:0]                 neg;
        logic [N_OPS-1:0][SEL_W-1:0]      sel;
    } rule_word_t;

    localparam int RULE_W = $bits(rule_word_t);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLEAR = 2'd1,
        ST_RUN   = 2'd2
    } ctrl_state_t;

    function automatic logic [ALPHA_W-1:0] lvl_max(input logic [ALPHA_W-1:0] a,
                                                   input logic [ALPHA_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [ALPHA_W-1:0] lvl_min(input logic [ALPHA_W-1:0] a,
                                                   input logic [ALPHA_W-1:0] b);
        return (a < b) ? a : b;
    endfunction
endpackage

// File: rtl/theta_rule_eval.sv
`timescale 1ns/1ps
module theta_rule_eval
    import theta_pkg::*;
(
    input  logic [BANK_W-1:0]  alpha_i,
    input  rule_word_t         rule_i,
    output logic [ALPHA_W-1:0] theta_o
);
    localparam logic [ALPHA_W-1:0] LVL_TOP = '1;

    logic [ALPHA_W-1:0] opnd [N_OPS];

    for (genvar k = 0; k < N_OPS; k++) begin : g_opnd
        logic [ALPHA_W-1:0] raw;
        always_comb begin
            raw     = alpha_i[int'(rule_i.sel[k]) * ALPHA_W +: ALPHA_W];
            opnd[k] = rule_i.neg[k] ? (LVL_TOP - raw) : raw;
        end
    end

    always_comb begin
        theta_o = opnd[0];
        for (int k = 1; k < N_OPS; k++) begin
            if (k <= int'(rule_i.cnt_m1)) begin
                theta_o = rule_i.conn[k-1] ? lvl_max(theta_o, opnd[k])
                                           : lvl_min(theta_o, opnd[k]);
            end
        end
    end
endmodule

// File: rtl/theta_ctrl.sv
`timescale 1ns/1ps
module theta_ctrl
    import theta_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic accept_i,
    input  logic last_i,
    output logic rdy_o,
    output logic clr_o
);
    ctrl_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_CLEAR;
            ST_CLEAR: state_d = ST_RUN;
            ST_RUN:   if (accept_i && last_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rdy_o = 1'b0;
        clr_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_CLEAR: clr_o = 1'b1;
            ST_RUN:   rdy_o = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/theta_bank.sv
`timescale 1ns/1ps
module theta_bank
    import theta_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               upd_i,
    input  logic [CONS_W-1:0]  cons_i,
    input  logic [ALPHA_W-1:0] theta_i,
    input  logic               last_i,
    output logic               out_vld_o,
    output logic [ALPHA_W-1:0] out_theta_o,
    output logic [CONS_W-1:0]  out_cons_o,
    output logic               done_o
);
    logic [ALPHA_W-1:0] th_q [N_CONS];
    logic [ALPHA_W-1:0] merged;

    assign merged = lvl_max(th_q[cons_i], theta_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < N_CONS; c++) th_q[c] <= '0;
        end else if (clr_i) begin
            for (int c = 0; c < N_CONS; c++) th_q[c] <= '0;
        end else if (upd_i) begin
            th_q[cons_i] <= merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld_o   <= 1'b0;
            out_theta_o <= '0;
            out_cons_o  <= '0;
            done_o      <= 1'b0;
        end else begin
            out_vld_o <= upd_i;
            done_o    <= upd_i && last_i;
            if (upd_i) begin
                out_theta_o <= merged;
                out_cons_o  <= cons_i;
            end
        end
    end
endmodule

// File: rtl/theta_eval.sv
`timescale 1ns/1ps
module theta_eval
    import theta_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [BANK_W-1:0]    alpha_i,
    input  logic                 rule_vld_i,
    input  logic [RULE_W-1:0]    rule_i,
    output logic                 rule_rdy_o,
    output logic                 theta_vld_o,
    output logic [ALPHA_W-1:0]   theta_o,
    output logic [CONS_W-1:0]    cons_o,
    output logic                 done_o
);
    rule_word_t         word;
    logic               accept;
    logic               clr;
    logic [ALPHA_W-1:0] rule_theta;

    assign word   = rule_word_t'(rule_i);
    assign accept = rule_vld_i && rule_rdy_o;

    theta_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .accept_i (accept),
        .last_i   (word.last),
        .rdy_o    (rule_rdy_o),
        .clr_o    (clr)
    );

    theta_rule_eval u_eval (
        .alpha_i (alpha_i),
        .rule_i  (word),
        .theta_o (rule_theta)
    );

    theta_bank u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr),
        .upd_i       (accept),
        .cons_i      (word.cons),
        .theta_i     (rule_theta),
        .last_i      (word.last),
        .out_vld_o   (theta_vld_o),
        .out_theta_o (theta_o),
        .out_cons_o  (cons_o),
        .done_o      (done_o)
    );
endmodule

// File: rtl/theta_eval_chk.sv
`timescale 1ns/1ps
module theta_eval_chk
    import theta_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               rule_vld_i,
    input logic [RULE_W-1:0]  rule_i,
    input logic               rule_rdy_o,
    input logic               theta_vld_o,
    input logic [ALPHA_W-1:0] theta_o,
    input logic [CONS_W-1:0]  cons_o,
    input logic               done_o
);
    rule_word_t w;
    logic       acc;
    assign w   = rule_word_t'(rule_i);
    assign acc = rule_vld_i && rule_rdy_o;

    AST_OUT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> theta_vld_o); // R6
    AST_OUT_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        theta_vld_o |-> $past(acc)); // R5
    AST_CONS_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (cons_o == $past(w.cons))); // R6
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && w.last) |=> (done_o && !rule_rdy_o)); // R7
    AST_DONE_ONLY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(acc && w.last)); // R7
    AST_MERGE_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
        (theta_vld_o && $past(theta_vld_o) && cons_o == $past(cons_o))
            |-> (theta_o >= $past(theta_o))); // R6
endmodule

bind theta_eval theta_eval_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rule_vld_i  (rule_vld_i),
    .rule_i      (rule_i),
    .rule_rdy_o  (rule_rdy_o),
    .theta_vld_o (theta_vld_o),
    .theta_o     (theta_o),
    .cons_o      (cons_o),
    .done_o      (done_o)
);

// File: tb/sim_theta_eval.sv
`timescale 1ns/1ps
module sim_theta_eval;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] alpha_i = '0;
    logic        rule_vld_i = 1'b0;
    logic [32:0] rule_i = '0;
    logic        rule_rdy_o, theta_vld_o, done_o;
    logic [3:0]  theta_o;
    logic [6:0]  cons_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    bit in_run = 0;
    logic [3:0] ref_th [128];

    always #2.5 clk = ~clk;

    theta_eval u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .alpha_i(alpha_i),
        .rule_vld_i(rule_vld_i), .rule_i(rule_i), .rule_rdy_o(rule_rdy_o),
        .theta_vld_o(theta_vld_o), .theta_o(theta_o), .cons_o(cons_o),
        .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [32:0] mk(input logic [15:0] sels, input logic [3:0] neg,
                                       input logic [2:0] conn, input logic [6:0] cons,
                                       input logic [1:0] cnt, input logic last);
        return {last, cnt, cons, conn, neg, sels};
    endfunction

    function automatic logic [3:0] ref_eval(input logic [63:0] a, input logic [32:0] w);
        logic [3:0] op [4];
        logic [3:0] acc;
        for (int k = 0; k < 4; k++) begin
            logic [3:0] s;
            s = w[k*4 +: 4];
            op[k] = a[int'(s)*4 +: 4];
            if (w[16+k]) op[k] = 4'd15 - op[k];
        end
        acc = op[0];
        for (int k = 1; k <= int'(w[31:30]); k++) begin
            if (w[19+k]) acc = (acc > op[k]) ? acc : op[k];
            else         acc = (acc < op[k]) ? acc : op[k];
        end
        return acc;
    endfunction

    // Offer one word (or nothing) at a falling edge; check results at the next one.
    task automatic step(input logic [32:0] w, input logic v, input logic st, input string tag);
        bit acc;
        logic [3:0] e;
        acc = v && in_run;
        if (acc) chk(rule_rdy_o == 1'b1, "R5 ready in run", rule_rdy_o, 1);
        rule_i = w; rule_vld_i = v; start_i = st;
        @(negedge clk);
        rule_vld_i = 1'b0; start_i = 1'b0;
        if (acc) begin
            e = ref_eval(alpha_i, w);
            if (ref_th[w[29:23]] > e) e = ref_th[w[29:23]];
            ref_th[w[29:23]] = e;
            chk(theta_vld_o == 1'b1, {tag, " R6 valid"}, theta_vld_o, 1);
            chk(theta_o == e, {tag, " theta"}, theta_o, e);
            chk(cons_o == w[29:23], {tag, " R6 cons"}, cons_o, w[29:23]);
            chk(done_o == w[32], {tag, " R7 done"}, done_o, w[32]);
            if (w[32]) begin
                chk(rule_rdy_o == 1'b0, "R7 idle after last", rule_rdy_o, 0);
                in_run = 0;
            end
        end else begin
            chk(theta_vld_o == 1'b0, {tag, " R5 no output"}, theta_vld_o, 0);
            chk(done_o == 1'b0, {tag, " R5 no done"}, done_o, 0);
        end
    endtask

    task automatic do_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(rule_rdy_o == 1'b0, "R2 clear cycle", rule_rdy_o, 0);
        @(negedge clk);
        chk(rule_rdy_o == 1'b1, "R2 run after clear", rule_rdy_o, 1);
        for (int c = 0; c < 128; c++) ref_th[c] = 4'd0;
        in_run = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 128; c++) ref_th[c] = 4'd0;
        repeat (3) @(negedge clk);
        chk(rule_rdy_o == 1'b0, "R1 ready in reset", rule_rdy_o, 0);
        chk(theta_vld_o == 1'b0, "R1 valid in reset", theta_vld_o, 0);
        chk(done_o == 1'b0, "R1 done in reset", done_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rule_rdy_o == 1'b0, "R1 ready after reset", rule_rdy_o, 0);

        // R5: word offered while idle is dropped
        step(mk(16'h0000, 4'h1, 3'd0, 7'd3, 2'd0, 1'b0), 1'b1, 1'b0, "R5 idle word");

        // R3: every alpha level, plain and complemented
        for (int i = 0; i < 16; i++) alpha_i[i*4 +: 4] = 4'((i*5 + 2) % 16);
        do_start();
        for (int s = 0; s < 16; s++) begin
            for (int n = 0; n < 2; n++) begin
                step(mk({12'h000, 4'(s)}, {3'b000, 1'(n)}, 3'd0, 7'(n*16 + s), 2'd0,
                        (s == 15 && n == 1)), 1'b1, 1'b0, "R3 single");
            end
        end

        // R4/R6: all connective patterns, counts and polarities, merged into few consequents
        for (int b = 0; b < 3; b++) begin
            for (int i = 0; i < 16; i++) alpha_i[i*4 +: 4] = 4'((i*(2*b + 3) + b*5) % 16);
            do_start();
            for (int cn = 0; cn < 8; cn++) begin
                for (int ct = 0; ct < 4; ct++) begin
                    for (int ng = 0; ng < 16; ng++) begin
                        step(mk({4'((ng + b*4) % 16), 4'((ng*3 + 6) % 16),
                                 4'((ng + 11) % 16), 4'((ng*7 + b) % 16)},
                                4'(ng), 3'(cn), {3'(cn), 2'(ct), 2'(b)}, 2'(ct),
                                (cn == 7 && ct == 3 && ng == 15)),
                             1'b1, 1'b0, "R4 combine");
                    end
                end
            end
        end

        // R8: start inside a process is ignored, registers keep values
        alpha_i = '0;
        do_start();
        step(mk(16'h0000, 4'h1, 3'd0, 7'd5, 2'd0, 1'b0), 1'b1, 1'b0, "R8 load");
        step('0, 1'b0, 1'b1, "R8 start in run");
        chk(rule_rdy_o == 1'b1, "R8 still running", rule_rdy_o, 1);
        step(mk(16'h0000, 4'h0, 3'd0, 7'd5, 2'd0, 1'b1), 1'b1, 1'b0, "R8 kept");
        chk(theta_o == 4'd15, "R8 theta kept", theta_o, 15);

        // R9: new process starts from zero
        do_start();
        step(mk(16'h0000, 4'h0, 3'd0, 7'd5, 2'd0, 1'b1), 1'b1, 1'b0, "R9 fresh");
        chk(theta_o == 4'd0, "R9 cleared", theta_o, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule